// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple single-word host port and a four-bank, 16-bit synchronous DRAM. It brings the memory out of power-up and then serves one host read or write at a time. A host access opens the addressed row, transfers one word with the auto-precharge flag set, and lets the memory close the row by itself. Periodic auto-refresh commands are slotted in between host accesses.

The host raises `req_i` with a word address, a direction and, for writes, the data, and holds them until `ack_o` pulses for one cycle. The host drops `req_i` in the cycle after the pulse. For a write, the pulse comes with the WRITE command. For a read, it comes with the returned word on `rdata_o`. Every memory-side pin is driven from a flop that is clocked on the rising edge. Every timing gap is a parameter counted in clock cycles, and NOPs are issued until each gap has run out.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is asserted, CKE is low, the command is NOP, `ack_o` is low and the data bus is not driven.
- R2: After reset, and no earlier than T_INIT cycles, the controller issues these commands in order: PRECHARGE with A10 high, AUTO REFRESH T_RP cycles later, a second AUTO REFRESH T_RC cycles later, and then LOAD MODE T_RC cycles later. The LOAD MODE address carries CAS_LAT in A[6:4] and zero in all other bits, which selects single-word sequential bursts.
- R3: No ACTIVE, READ or WRITE command is issued before LOAD MODE, even if a request is already pending.
- R4: The word address is split as {bank[21:20], row[19:8], column[7:0]}. ACTIVE drives the bank on BA and the row on A. READ and WRITE drive the same bank on BA, the column on A[7:0] and A10 high, which requests auto-precharge.
- R5: READ or WRITE follows its ACTIVE after exactly T_RCD cycles.
- R6: A write drives `wdata_i` on DQ with output enable high and DQM low, only in the WRITE command cycle, and pulses `ack_o` in that same cycle.
- R7: A read samples DQ CAS_LAT cycles after the memory registers the READ. It presents the word on `rdata_o` with `ack_o` in the following cycle, which is CAS_LAT+1 cycles after READ appears on the pins.
- R8: ACTIVE commands are at least T_RC cycles apart, any command after an AUTO REFRESH waits at least T_RC cycles, and the next command after a WRITE waits at least T_WR+T_RP cycles, with T_WR fixed at 2.
- R9: Once initialization is done, an AUTO REFRESH is issued every T_REFI cycles. A pending refresh wins over a host request whenever the controller is idle, so refreshes stay close to T_REFI apart even under back-to-back traffic.
- R10: Commands use {CS_n, RAS_n, CAS_n, WE_n} with ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001, LOAD MODE=0000 and NOP=0111. No other code appears.
- R11: `ack_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, held until acknowledged |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 22 | Word address {bank, row, column} |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | One-cycle acknowledge |
| rdata_o | output | 16 | Read data, valid with ack_o on reads |
| sd_cke_o | output | 1 | Clock enable |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | 2 | Bank address |
| sd_a_o | output | 12 | Row, column or mode address |
| sd_dqm_o | output | 2 | Byte masks |
| sd_dq_o | output | 16 | Write data to the pad |
| sd_dq_oe_o | output | 1 | Pad output enable |
| sd_dq_i | input | 16 | Read data from the pad |

## Verification
The bench builds the controller with T_INIT=10, T_RCD=2, CAS_LAT=2, T_RP=2, T_RC=7 and T_REFI=80. With these values the whole initialization sequence and many refresh periods fit in a short run. Writes and reads then sweep every bank against the row and column extremes plus a mixed value, with requests arriving back to back. This puts refresh collisions with host traffic, read latency alignment and every minimum spacing within reach of exact cycle checks.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int AP_BIT = 10;
  localparam int T_WR   = 2;
  localparam int T_MRD  = 2;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_RW, ST_CAP
  } seq_st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdram_delay_cnt.sv
module sdram_delay_cnt #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= W'(RST_VAL);
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int T_REFI = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic pend_o
);
  localparam int W = $clog2(T_REFI + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else if (cnt_q == W'(T_REFI - 1)) begin
      cnt_q  <= '0;
      pend_o <= 1'b1;  // expiry wins over a same-cycle clear
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (clr_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int T_INIT  = 20000,
  parameter int T_RCD   = 3,
  parameter int CAS_LAT = 3,
  parameter int T_RP    = 3,
  parameter int T_RC    = 10,
  parameter int T_REFI  = 1500
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic                            ack_o,
  output logic [DATA_W-1:0]               rdata_o,
  output logic                            sd_cke_o,
  output logic                            sd_cs_no,
  output logic                            sd_ras_no,
  output logic                            sd_cas_no,
  output logic                            sd_we_no,
  output logic [BANK_W-1:0]               sd_ba_o,
  output logic [ROW_W-1:0]                sd_a_o,
  output logic [DATA_W/8-1:0]             sd_dqm_o,
  output logic [DATA_W-1:0]               sd_dq_o,
  output logic                            sd_dq_oe_o,
  input  logic [DATA_W-1:0]               sd_dq_i
);
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int GAP_W  = imax(T_WR + T_RP, T_RC - T_RCD);
  localparam int GAP_R  = imax(1, imax(T_RP - CAS_LAT, T_RC - T_RCD - CAS_LAT - 1));
  localparam int MAXD   = imax(imax(T_INIT, T_RC), imax(imax(GAP_W, GAP_R), CAS_LAT + 1));
  localparam int CNT_W  = $clog2(MAXD + 1);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  seq_st_e           st_q, st_n;
  sd_cmd_e           cmd_q, cmd_n;
  logic [BANK_W-1:0] ba_n;
  logic [ROW_W-1:0]  a_n;
  logic [DATA_W-1:0] dq_n;
  logic              oe_n, ack_n, cap, ld, ref_clr, init_done_q, cnt_zero, ref_pend;
  logic [CNT_W-1:0]  ld_val;

  wire [BANK_W-1:0] f_bank = addr_i[ADDR_W-1 -: BANK_W];
  wire [ROW_W-1:0]  f_row  = addr_i[COL_W +: ROW_W];
  wire [COL_W-1:0]  f_col  = addr_i[COL_W-1:0];

  sdram_delay_cnt #(.W(CNT_W), .RST_VAL(T_INIT - 1)) u_wait (
    .clk_i, .rst_ni, .load_i(ld), .val_i(ld_val), .zero_o(cnt_zero)
  );

  sdram_refresh_timer #(.T_REFI(T_REFI)) u_refi (
    .clk_i, .rst_ni, .en_i(init_done_q), .clr_i(ref_clr), .pend_o(ref_pend)
  );

  always_comb begin
    st_n    = st_q;
    cmd_n   = CMD_NOP;
    ba_n    = sd_ba_o;
    a_n     = sd_a_o;
    dq_n    = sd_dq_o;
    oe_n    = 1'b0;
    ack_n   = 1'b0;
    cap     = 1'b0;
    ld      = 1'b0;
    ld_val  = '0;
    ref_clr = 1'b0;
    if (cnt_zero) begin
      unique case (st_q)
        ST_PWR: begin
          cmd_n = CMD_PRE;  a_n = '0;  a_n[AP_BIT] = 1'b1;
          ld = 1'b1;  ld_val = CNT_W'(T_RP - 1);  st_n = ST_IREF1;
        end
        ST_IREF1: begin
          cmd_n = CMD_REF;  ld = 1'b1;  ld_val = CNT_W'(T_RC - 1);  st_n = ST_IREF2;
        end
        ST_IREF2: begin
          cmd_n = CMD_REF;  ld = 1'b1;  ld_val = CNT_W'(T_RC - 1);  st_n = ST_IMRS;
        end
        ST_IMRS: begin
          cmd_n = CMD_LMR;  a_n = MODE_WORD;  ba_n = '0;
          ld = 1'b1;  ld_val = CNT_W'(T_MRD - 1);  st_n = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_n = CMD_REF;  ref_clr = 1'b1;
            ld = 1'b1;  ld_val = CNT_W'(T_RC - 1);
          end else if (req_i) begin
            cmd_n = CMD_ACT;  ba_n = f_bank;  a_n = f_row;
            ld = 1'b1;  ld_val = CNT_W'(T_RCD - 1);  st_n = ST_RW;
          end
        end
        ST_RW: begin
          ba_n = f_bank;  a_n = '0;  a_n[COL_W-1:0] = f_col;  a_n[AP_BIT] = 1'b1;
          ld = 1'b1;
          if (we_i) begin
            cmd_n = CMD_WR;  oe_n = 1'b1;  dq_n = wdata_i;  ack_n = 1'b1;
            ld_val = CNT_W'(GAP_W - 1);  st_n = ST_IDLE;
          end else begin
            cmd_n = CMD_RD;  ld_val = CNT_W'(CAS_LAT);  st_n = ST_CAP;
          end
        end
        ST_CAP: begin
          cap = 1'b1;  ack_n = 1'b1;
          ld = 1'b1;  ld_val = CNT_W'(GAP_R - 1);  st_n = ST_IDLE;
        end
        default: st_n = ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_PWR;
      cmd_q       <= CMD_NOP;
      sd_ba_o     <= '0;
      sd_a_o      <= '0;
      sd_dq_o     <= '0;
      sd_dq_oe_o  <= 1'b0;
      ack_o       <= 1'b0;
      rdata_o     <= '0;
      sd_cke_o    <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      st_q       <= st_n;
      cmd_q      <= cmd_n;
      sd_ba_o    <= ba_n;
      sd_a_o     <= a_n;
      sd_dq_o    <= dq_n;
      sd_dq_oe_o <= oe_n;
      ack_o      <= ack_n;
      sd_cke_o   <= 1'b1;
      if (cap) rdata_o <= sd_dq_i;
      if (cmd_n == CMD_LMR) init_done_q <= 1'b1;
    end
  end

  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd_q;
  assign sd_dqm_o = {(DATA_W/8){~init_done_q}};
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RC  = 10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] cmd_i,
  input logic       a_ap_i,
  input logic       dq_oe_i,
  input logic       ack_i,
  input logic       cke_i
);
  localparam int SW = $clog2(T_RC + T_RCD + 2) + 1;
  localparam logic [SW-1:0] SMAX = '1;

  logic [SW-1:0] since_act, since_ref;
  logic          mrs_seen;
  wire is_act  = (cmd_i == CMD_ACT);
  wire is_ref  = (cmd_i == CMD_REF);
  wire is_rdwr = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= SMAX;
      since_ref <= SMAX;
      mrs_seen  <= 1'b0;
    end else begin
      since_act <= is_act ? SW'(1) : ((since_act == SMAX) ? SMAX : since_act + 1'b1);
      since_ref <= is_ref ? SW'(1) : ((since_ref == SMAX) ? SMAX : since_ref + 1'b1);
      if (cmd_i == CMD_LMR) mrs_seen <= 1'b1;
    end
  end

  assert_rcd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rdwr |-> since_act == SW'(T_RCD));
  assert_act_spacing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> since_act >= SW'(T_RC));
  assert_ref_spacing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act || is_ref) |-> since_ref >= SW'(T_RC));
  assert_autopre_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rdwr |-> a_ap_i);
  assert_oe_only_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_i |-> cmd_i == CMD_WR);
  assert_ack_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ack_i);
  assert_no_early_access_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act || is_rdwr) |-> mrs_seen);
  assert_legal_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i inside {CMD_LMR, CMD_REF, CMD_PRE, CMD_ACT, CMD_WR, CMD_RD, CMD_NOP});
  assert_cke_up_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_seen |-> cke_i);
endmodule

bind sdram_seq_ctrl sdram_seq_chk #(.T_RCD(T_RCD), .T_RC(T_RC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cmd_i   ({sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no}),
  .a_ap_i  (sd_a_o[sdram_seq_pkg::AP_BIT]),
  .dq_oe_i (sd_dq_oe_o),
  .ack_i   (ack_o),
  .cke_i   (sd_cke_o)
);

// File: tb/sdram_seq_ctrl_tb.sv
module sdram_seq_ctrl_tb;
  localparam int T_INIT = 10, T_RCD = 2, CL = 2, T_RP = 2, T_RC = 7, T_REFI = 80;
  localparam int T_WR = 2, SLACK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [21:0] addr = '0;
  logic [15:0] wdata = '0, sd_dq_i = 16'hDEAD;
  logic ack, cke, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [15:0] rdata, dq_o;
  logic [1:0] ba, dqm;
  logic [11:0] a;

  always #2.5 clk = ~clk;

  sdram_seq_ctrl #(.T_INIT(T_INIT), .T_RCD(T_RCD), .CAS_LAT(CL), .T_RP(T_RP),
                   .T_RC(T_RC), .T_REFI(T_REFI)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack), .rdata_o(rdata), .sd_cke_o(cke), .sd_cs_no(cs_n), .sd_ras_no(ras_n),
    .sd_cas_no(cas_n), .sd_we_no(we_n), .sd_ba_o(ba), .sd_a_o(a), .sd_dqm_o(dqm),
    .sd_dq_o(dq_o), .sd_dq_oe_o(dq_oe), .sd_dq_i(sd_dq_i)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int stage = 0, t_last = 0, t_act = -1000, t_wr = -1000, t_ref = 0, t_init = 0;
  int n_ref = 0, rd_due = -1, t_rd = 0;
  logic [15:0] rd_val = '0;
  logic [15:0] mem [int];
  logic [15:0] shadow [int];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [21:0] x);
    return x[15:0] ^ x[21:6];
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 50000) begin
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  // memory model and command monitor; a command seen here is registered at the next edge
  always @(negedge clk) if (rst_n) begin
    logic [3:0] c;
    c = {cs_n, ras_n, cas_n, we_n};
    if (c != 4'b0111 && stage < 4) begin
      case (stage)
        0: begin
          chk(c == 4'b0010, "R2 first cmd PRE", c, 4'b0010);
          chk(a[10] && cyc >= T_INIT, "R2 PRE A10/time", cyc, T_INIT);
        end
        1: begin
          chk(c == 4'b0001, "R2 REF1", c, 4'b0001);
          chk(cyc - t_last == T_RP, "R2 PRE-REF gap", cyc - t_last, T_RP);
        end
        2: begin
          chk(c == 4'b0001, "R2 REF2", c, 4'b0001);
          chk(cyc - t_last == T_RC, "R2 REF-REF gap", cyc - t_last, T_RC);
        end
        default: begin
          chk(c == 4'b0000, "R2 LOAD MODE", c, 4'b0000);
          chk(cyc - t_last == T_RC, "R2 REF-LMR gap", cyc - t_last, T_RC);
          chk(a == 12'(CL << 4), "R2 mode word", a, CL << 4);
          t_ref = cyc;
          t_init = cyc;
        end
      endcase
      if (c == 4'b0011 || c == 4'b0100 || c == 4'b0101)
        chk(0, "R3 access during init", c, 4'b0111);
      t_last = cyc;
      stage++;
    end else if (c != 4'b0111) begin
      case (c)
        4'b0001: begin
          n_ref++;
          chk(cyc - t_ref <= T_REFI + SLACK && (n_ref == 1 || cyc - t_ref >= T_REFI - SLACK),
              "R9 refresh interval", cyc - t_ref, T_REFI);
          t_ref = cyc;
        end
        4'b0011: begin
          chk(ba == addr[21:20] && a == addr[19:8], "R4 ACT bank/row", {ba, a}, addr[21:8]);
          chk(cyc - t_act >= T_RC, "R8 ACT spacing", cyc - t_act, T_RC);
          chk(cyc - t_wr >= T_WR + T_RP, "R8 write recovery", cyc - t_wr, T_WR + T_RP);
          t_act = cyc;
        end
        4'b0100, 4'b0101: begin
          chk(cyc - t_act == T_RCD, "R5 ACT to column cmd", cyc - t_act, T_RCD);
          chk(ba == addr[21:20] && a[7:0] == addr[7:0] && a[10],
              "R4 column/bank/A10", {ba, a}, {addr[21:20], 4'b0100, addr[7:0]});
          if (c == 4'b0100) begin
            chk(dq_oe && dq_o == wdata && dqm == 2'b00, "R6 write data", dq_o, wdata);
            chk(ack, "R6 write ack", ack, 1);
            mem[int'(addr)] = dq_o;
            t_wr = cyc;
          end else begin
            rd_due = cyc + CL;
            t_rd = cyc;
            rd_val = mem.exists(int'(addr)) ? mem[int'(addr)] : pat(addr);
          end
        end
        default: chk(0, "R10 illegal command", c, 4'b0111);
      endcase
    end
    if (dq_oe && c != 4'b0100) chk(0, "R6 bus driven outside WRITE", c, 4'b0100);
    sd_dq_i = (cyc == rd_due) ? rd_val : 16'hDEAD;
  end

  task automatic access(input bit w, input logic [21:0] ad, input logic [15:0] d);
    logic [15:0] e;
    addr = ad; wdata = d; we = w;
    req = 1'b1;
    do @(negedge clk); while (!ack);
    if (w) shadow[int'(ad)] = d;
    else begin
      e = shadow.exists(int'(ad)) ? shadow[int'(ad)] : pat(ad);
      chk(rdata == e, "R7 read data", rdata, e);
      chk(cyc - t_rd == CL + 1, "R7 read latency", cyc - t_rd, CL + 1);
    end
    req = 1'b0;
    @(negedge clk);
    chk(!ack, "R11 ack single pulse", ack, 0);
  endtask

  initial begin
    logic [11:0] rows [4];
    logic [7:0]  cols [4];
    rows = '{12'h000, 12'h001, 12'hA5A, 12'hFFF};
    cols = '{8'h00, 8'h01, 8'h7F, 8'hFF};
    repeat (3) @(negedge clk);
    chk(!cke && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && !ack && !dq_oe,
        "R1 reset state", {cke, cs_n, ras_n, cas_n, we_n, ack, dq_oe}, 7'b0011100);
    rst_n = 1'b1;
    // request pending from the start exercises R3
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 4; r++)
        for (int k = 0; k < 4; k++)
          access(1'b1, {2'(b), rows[r], cols[k]}, 16'hA5C3 ^ {2'(b), rows[r], cols[k]}[15:0] ^ 16'(r * 77));
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 4; r++)
        for (int k = 0; k < 4; k++)
          access(1'b0, {2'(b), rows[r], cols[k]}, 16'h0);
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 4; k++)
        access(1'b0, {2'(b), 12'h3C3, cols[k]}, 16'h0);
    access(1'b1, 22'h3FFFFF, 16'hFFFF);
    access(1'b0, 22'h3FFFFF, 16'h0);
    repeat (400) @(negedge clk);
    chk(n_ref >= (cyc - t_init) / T_REFI - 1 && n_ref <= (cyc - t_init) / T_REFI + 1,
        "R9 refresh count", n_ref, (cyc - t_init) / T_REFI);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule